// File: doc/BRIEF.md
# Message-Signalled Interrupt File

This block is the interrupt file of one hart. It takes interrupts as messages: a device writes an identity number into a 4 KiB page, and the file marks that identity pending. Each identity also has an enable bit. Software reaches both bit arrays, a delivery switch and a priority threshold through an indirect port: a selector picks a register and a data operation (write, set bits, clear bits) acts on it in one cycle.

A priority search picks the eligible identity with the lowest number. Its number appears on the top register. A claim pulse clears the pending bit of that identity in the same cycle that software reads it, so a read and its claim act as one access. The external-interrupt line rises when delivery is on and some identity is eligible.

Parameters set the number of identities (`NUM_IDS`, of the form 64k-1 from 63 to 2047) and the data width of the indirect port (`XLEN`, 32 or 64). In what follows, `ID_W` is the number of bits needed to hold `NUM_IDS`.

Top module: `msi_intr_file`

## Requirements
- R1: A write with `msg_wr` high, `msg_addr` = 0x000 and `msg_data` = n (little-endian, taken as is) sets pending bit n. The new bit is visible after the next rising clock edge.
- R2: A write to `msg_addr` = 0x004 takes the identity from `msg_data` with its four bytes reversed, then acts as in R1.
- R3: A message write has no effect in these cases: the offset is neither 0x000 nor 0x004, the decoded identity is 0, or the decoded identity exceeds `NUM_IDS`.
- R4: The pending array sits at selectors from 0x80 and the enable array at selectors from 0xC0. Identity n is at selector base + (n/XLEN)*(XLEN/32), bit n mod XLEN. With XLEN=64, odd selectors read zero and ignore writes.
- R5: The `ind_op` encoding is 0 = write, 1 = set the bits that are one in `ind_wdata`, 2 = clear those bits, and 3 = no change. The operation acts on the selected register at the clock edge while `ind_wr` is high.
- R6: The pending and enable bits of identity 0 always read zero and ignore every write.
- R7: Selector 0x70 is the delivery switch (bit 0). Selector 0x72 is the threshold (the low ID_W bits). Every other selector that is not mapped reads zero and ignores writes. `ind_rdata` shows the selected register without delay.
- R8: `top_value` carries the lowest-numbered eligible identity in bits 26:16 and again in bits 10:0, with all other bits zero. It is all zero when no identity is eligible. An identity is eligible when it is both pending and enabled and it passes the threshold.
- R9: A threshold of 0 masks nothing. A nonzero threshold t leaves only identities below t eligible, so t = 1 masks every identity.
- R10: At a clock edge with `top_claim` high, the pending bit of the identity shown on `top_value` is cleared. When `top_value` is zero, a claim changes nothing. A message setting the same identity in that cycle wins over the claim.
- R11: `ext_irq` is high exactly when delivery is on and `top_value` is nonzero.
- R12: After a synchronous active-low reset, all pending and enable bits, the delivery switch and the threshold are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| msg_wr | input | 1 | Message write strobe |
| msg_addr | input | 12 | Byte offset of the message write within the page |
| msg_data | input | 32 | Message write data |
| ind_wr | input | 1 | Indirect operation strobe |
| ind_sel | input | 8 | Indirect register selector |
| ind_op | input | 2 | Indirect operation: 0 write, 1 set, 2 clear, 3 none |
| ind_wdata | input | XLEN | Indirect operand |
| ind_rdata | output | XLEN | Contents of the selected register |
| top_claim | input | 1 | Claim the identity now shown on `top_value` |
| top_value | output | 32 | Winning identity in bits 26:16 and 10:0 |
| ext_irq | output | 1 | External interrupt request |

## Verification
Checks that run on every cycle cover several behaviours. A valid message sets its pending bit on the next cycle. Offsets other than the two message offsets never produce a set. The winner is always both pending and enabled, and it is below any nonzero threshold. A claim removes the winner's pending bit unless a message for the same identity arrives in that cycle. The interrupt line implies that delivery is on and that a pending winner exists.

Some properties can only be shown by the bench's scenarios. These are the byte reversal at the second offset, the selector-to-bit mapping, the meaning of each operation code, and the rule that the lowest number wins rather than just any eligible identity. They also include the full sweep of thresholds, and the fact that rejected identities and stray offsets leave the readable state untouched.

// File: rtl/msif_pkg.sv
// Shared definitions for the message-signalled interrupt file.
// Assumes an 8-bit indirect selector space; the selector values below
// are decoded by the CPU side and must not move.
package msif_pkg;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } ind_op_e;

    localparam logic [7:0] SEL_DELIVER   = 8'h70;
    localparam logic [7:0] SEL_THRESH    = 8'h72;
    localparam logic [7:0] SEL_PEND_BASE = 8'h80;
    localparam logic [7:0] SEL_EN_BASE   = 8'hC0;

    // Applies one indirect operation to a single register bit.
    function automatic logic op_bit(ind_op_e op, logic old_b, logic wd_b);
        case (op)
            OP_WRITE: op_bit = wd_b;
            OP_SET:   op_bit = old_b | wd_b;
            OP_CLEAR: op_bit = old_b & ~wd_b;
            default:  op_bit = old_b;
        endcase
    endfunction

endpackage

// File: rtl/msif_msg_decode.sv
// Message page decoder. Turns a 32-bit write into the page into a
// request to set one pending bit. Offset 0x000 carries the identity
// little-endian, offset 0x004 big-endian; any other offset, identity 0
// or an identity above NUM_IDS yields no request. Purely combinational.
module msif_msg_decode #(
    parameter int NUM_IDS = 63,
    parameter int ID_W    = 6
) (
    input  logic            msg_wr,
    input  logic [11:0]     msg_addr,
    input  logic [31:0]     msg_data,
    output logic            set_valid,
    output logic [ID_W-1:0] set_id
);

    logic [31:0] id_raw;
    logic        off_ok;

    // Select byte order from the offset and flag the two legal offsets.
    always_comb begin : order_sel
        case (msg_addr)
            12'h000: begin
                id_raw = msg_data;
                off_ok = 1'b1;
            end
            12'h004: begin
                id_raw = {msg_data[7:0], msg_data[15:8], msg_data[23:16], msg_data[31:24]};
                off_ok = 1'b1;
            end
            default: begin
                id_raw = msg_data;
                off_ok = 1'b0;
            end
        endcase
    end

    assign set_valid = msg_wr && off_ok && (id_raw != 32'd0) && (id_raw <= 32'(NUM_IDS));
    assign set_id    = id_raw[ID_W-1:0];

endmodule

// File: rtl/msif_prio.sv
// Priority search. An identity is eligible when pending and enabled and,
// with a nonzero threshold, numbered below it. Returns the lowest
// eligible number, or zero. Identity 0 never wins. Linear, combinational.
module msif_prio #(
    parameter int NBITS = 64,
    parameter int ID_W  = 6
) (
    input  logic [NBITS-1:0] pend,
    input  logic [NBITS-1:0] en,
    input  logic [ID_W-1:0]  thresh,
    output logic [ID_W-1:0]  win_id
);

    logic [NBITS-1:0] elig;

    // Per-identity eligibility including the threshold mask.
    always_comb begin : elig_calc
        for (int i = 0; i < NBITS; i++) begin
            elig[i] = pend[i] && en[i] && ((thresh == '0) || (i < int'(thresh)));
        end
        elig[0] = 1'b0;
    end

    // Scan from the top so the lowest eligible number is left standing.
    always_comb begin : win_scan
        win_id = '0;
        for (int i = NBITS - 1; i >= 1; i--) begin
            if (elig[i]) win_id = ID_W'(i);
        end
    end

endmodule

// File: rtl/msi_intr_file.sv
// Per-hart interrupt file: pending and enable arrays, delivery switch and
// threshold behind an indirect select/data port, a message page decoder,
// a lowest-number priority search and a read-and-claim top register.
// Assumes NUM_IDS = 64k-1 (63..2047) and XLEN of 32 or 64, so each array
// fills whole XLEN-bit words. Within one edge: indirect op, then claim,
// then message set (a new message wins over a claim).
module msi_intr_file
    import msif_pkg::*;
#(
    parameter int NUM_IDS = 63,
    parameter int XLEN    = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            msg_wr,
    input  logic [11:0]     msg_addr,
    input  logic [31:0]     msg_data,
    input  logic            ind_wr,
    input  logic [7:0]      ind_sel,
    input  logic [1:0]      ind_op,
    input  logic [XLEN-1:0] ind_wdata,
    output logic [XLEN-1:0] ind_rdata,
    input  logic            top_claim,
    output logic [31:0]     top_value,
    output logic            ext_irq
);

    localparam int ID_W     = $clog2(NUM_IDS + 1);
    localparam int NBITS    = NUM_IDS + 1;
    localparam int NWORDS   = NBITS / XLEN;
    localparam int SEL_STEP = XLEN / 32;

    logic [NBITS-1:0] pend_q, pend_d, en_q, en_d;
    logic             deliver_q, deliver_d;
    logic [ID_W-1:0]  thr_q, thr_d;
    logic             set_v;
    logic [ID_W-1:0]  set_id;
    logic [ID_W-1:0]  win_id;
    logic [NWORDS-1:0] pend_hit, en_hit;
    ind_op_e          op;

    assign op = ind_op_e'(ind_op);

    msif_msg_decode #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_dec (
        .msg_wr    (msg_wr),
        .msg_addr  (msg_addr),
        .msg_data  (msg_data),
        .set_valid (set_v),
        .set_id    (set_id)
    );

    msif_prio #(.NBITS(NBITS), .ID_W(ID_W)) u_prio (
        .pend   (pend_q),
        .en     (en_q),
        .thresh (thr_q),
        .win_id (win_id)
    );

    // Selector match per array word; with 64-bit words only even selectors hit.
    for (genvar w = 0; w < NWORDS; w++) begin : g_word_hit
        assign pend_hit[w] = (ind_sel == 8'(int'(SEL_PEND_BASE) + w * SEL_STEP));
        assign en_hit[w]   = (ind_sel == 8'(int'(SEL_EN_BASE) + w * SEL_STEP));
    end

    // Next state: indirect op, then claim, then message set; bit 0 stays zero.
    always_comb begin : next_state
        pend_d    = pend_q;
        en_d      = en_q;
        deliver_d = deliver_q;
        thr_d     = thr_q;
        if (ind_wr) begin
            for (int w = 0; w < NWORDS; w++) begin
                for (int b = 0; b < XLEN; b++) begin
                    if (pend_hit[w]) pend_d[w*XLEN+b] = op_bit(op, pend_q[w*XLEN+b], ind_wdata[b]);
                    if (en_hit[w])   en_d[w*XLEN+b]   = op_bit(op, en_q[w*XLEN+b], ind_wdata[b]);
                end
            end
            if (ind_sel == SEL_DELIVER) deliver_d = op_bit(op, deliver_q, ind_wdata[0]);
            if (ind_sel == SEL_THRESH) begin
                for (int b = 0; b < ID_W; b++) thr_d[b] = op_bit(op, thr_q[b], ind_wdata[b]);
            end
        end
        if (top_claim && (win_id != '0)) pend_d[win_id] = 1'b0;
        if (set_v) pend_d[set_id] = 1'b1;
        pend_d[0] = 1'b0;
        en_d[0]   = 1'b0;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin : state_regs
        if (!rst_n) begin
            pend_q    <= '0;
            en_q      <= '0;
            deliver_q <= 1'b0;
            thr_q     <= '0;
        end else begin
            pend_q    <= pend_d;
            en_q      <= en_d;
            deliver_q <= deliver_d;
            thr_q     <= thr_d;
        end
    end

    // Read mux for the indirect port; unmapped selectors return zero.
    always_comb begin : read_mux
        ind_rdata = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (pend_hit[w]) ind_rdata = pend_q[w*XLEN +: XLEN];
            if (en_hit[w])   ind_rdata = en_q[w*XLEN +: XLEN];
        end
        if (ind_sel == SEL_DELIVER) ind_rdata = XLEN'(deliver_q);
        if (ind_sel == SEL_THRESH)  ind_rdata = XLEN'(thr_q);
    end

    assign top_value = {5'd0, 11'(win_id), 5'd0, 11'(win_id)};
    assign ext_irq   = deliver_q && (win_id != '0);

    // R1: an accepted message shows up as pending one edge later.
    p_set_pend_r1: assert property (@(posedge clk) disable iff (!rst_n)
        set_v |=> pend_q[$past(set_id)]);

    // R3: stray offsets never produce a set request.
    p_stray_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_wr && (msg_addr != 12'h000) && (msg_addr != 12'h004)) |-> !set_v);

    // R8: the winner is both pending and enabled.
    p_win_elig_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (win_id != '0) |-> (pend_q[win_id] && en_q[win_id]));

    // R9: a nonzero threshold bounds the winner.
    p_thresh_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_q != '0) |-> (win_id < thr_q));

    // R10: a claim removes the winner unless a message re-sets it.
    p_claim_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (top_claim && (win_id != '0) && !(set_v && (set_id == win_id)))
        |=> !pend_q[$past(win_id)]);

    // R11: the request line implies delivery and a pending winner.
    p_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ext_irq |-> (deliver_q && pend_q[win_id]));

endmodule

// File: tb/msi_intr_file_test.sv
module msi_intr_file_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_wr = 1'b0;
    logic [11:0] msg_addr = '0;
    logic [31:0] msg_data = '0;
    logic        ind_wr = 1'b0;
    logic [7:0]  ind_sel = '0;
    logic [1:0]  ind_op = '0;
    logic [31:0] ind_wdata = '0;
    logic [31:0] ind_rdata;
    logic        top_claim = 1'b0;
    logic [31:0] top_value;
    logic        ext_irq;

    int nchk = 0;
    int nfail = 0;

    logic [63:0] mp = '0;
    logic [63:0] me = '0;
    bit          md = 1'b0;
    int          mt = 0;
    logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

    always #5 clk = ~clk;

    msi_intr_file #(.NUM_IDS(63), .XLEN(32)) uut (
        .clk(clk), .rst_n(rst_n),
        .msg_wr(msg_wr), .msg_addr(msg_addr), .msg_data(msg_data),
        .ind_wr(ind_wr), .ind_sel(ind_sel), .ind_op(ind_op),
        .ind_wdata(ind_wdata), .ind_rdata(ind_rdata),
        .top_claim(top_claim), .top_value(top_value), .ext_irq(ext_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic msg(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        msg_wr = 1'b1; msg_addr = a; msg_data = d;
        @(negedge clk);
        msg_wr = 1'b0;
    endtask

    task automatic ind(input logic [7:0] s, input logic [1:0] o, input logic [31:0] d);
        @(negedge clk);
        ind_wr = 1'b1; ind_sel = s; ind_op = o; ind_wdata = d;
        @(negedge clk);
        ind_wr = 1'b0;
    endtask

    task automatic claim();
        @(negedge clk);
        top_claim = 1'b1;
        @(negedge clk);
        top_claim = 1'b0;
    endtask

    task automatic rd(input logic [7:0] s, output logic [31:0] v);
        ind_sel = s;
        #1;
        v = ind_rdata;
    endtask

    function automatic logic [31:0] bswap(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic int exp_top();
        int r = 0;
        for (int i = 63; i >= 1; i--)
            if (mp[i] && me[i] && (mt == 0 || i < mt)) r = i;
        return r;
    endfunction

    task automatic check_arrays(input string tag);
        logic [31:0] v;
        rd(8'h80, v); chk({tag, " pend w0"}, v, mp[31:0]);
        rd(8'h81, v); chk({tag, " pend w1"}, v, mp[63:32]);
        rd(8'hC0, v); chk({tag, " en w0"}, v, me[31:0]);
        rd(8'hC1, v); chk({tag, " en w1"}, v, me[63:32]);
    endtask

    task automatic check_top(input string tag);
        int t;
        t = exp_top();
        #1;
        chk({tag, " top"}, top_value, {5'd0, 11'(t), 5'd0, 11'(t)});
        chk({tag, " R11 irq"}, 32'(ext_irq), 32'(md && t != 0));
    endtask

    function automatic logic [63:0] next_rand(input logic [63:0] x);
        logic [63:0] y = x;
        y = y ^ (y << 13);
        y = y ^ (y >> 7);
        y = y ^ (y << 17);
        return y;
    endfunction

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin : stim
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        check_arrays("R12 reset");
        rd(8'h70, v); chk("R12 deliver", v, 32'd0);
        rd(8'h72, v); chk("R12 thresh", v, 32'd0);
        check_top("R12");

        // R5, R6: operation codes on the enable words, identity 0 stuck at zero
        ind(8'hC0, 2'd0, 32'hFFFF_FFFF); me[31:0] = 32'hFFFF_FFFE;
        check_arrays("R6 write all");
        ind(8'hC1, 2'd0, 32'hFFFF_FFFF); me[63:32] = 32'hFFFF_FFFF;
        check_arrays("R5 write");
        ind(8'hC1, 2'd2, 32'h0000_FF00); me[47:40] = 8'h00;
        check_arrays("R5 clear");
        ind(8'hC1, 2'd1, 32'h0000_0100); me[40] = 1'b1;
        check_arrays("R5 set");
        ind(8'hC1, 2'd3, 32'h0000_0000);
        check_arrays("R5 none");
        ind(8'h80, 2'd1, 32'h0000_0001);
        check_arrays("R6 pend id0");
        ind(8'hC1, 2'd1, 32'hFFFF_FFFF); me[63:32] = 32'hFFFF_FFFF;

        // R1, R4: little-endian sweep over every identity
        for (int id = 1; id <= 63; id++) begin
            msg(12'h000, 32'(id)); mp[id] = 1'b1;
            check_arrays("R1 R4 le sweep");
            check_top("R1 le sweep");
        end
        ind(8'h80, 2'd0, 32'd0); ind(8'h81, 2'd0, 32'd0); mp = '0;
        check_arrays("R5 pend cleared");

        // R2: big-endian sweep, each bit cleared again with a clear op
        for (int id = 1; id <= 63; id++) begin
            msg(12'h004, bswap(32'(id))); mp[id] = 1'b1;
            check_arrays("R2 be sweep");
            ind(id < 32 ? 8'h80 : 8'h81, 2'd2, 32'd1 << (id % 32)); mp[id] = 1'b0;
            check_arrays("R2 R5 be clear");
        end

        // R3: rejected identities and stray offsets
        msg(12'h000, 32'd0);          check_arrays("R3 id zero");
        msg(12'h000, 32'd64);         check_arrays("R3 id 64");
        msg(12'h000, 32'hFFFF_FFFF);  check_arrays("R3 id max");
        msg(12'h000, bswap(32'd5));   check_arrays("R3 le swapped");
        msg(12'h004, 32'd5);          check_arrays("R3 be unswapped");
        msg(12'h008, 32'd5);          check_arrays("R3 off 8");
        msg(12'h100, 32'd5);          check_arrays("R3 off 100");
        msg(12'hFFC, 32'd5);          check_arrays("R3 off ffc");
        msg(12'h001, 32'd5);          check_arrays("R3 off 1");

        // R7: delivery, threshold and unmapped selectors
        ind(8'h70, 2'd0, 32'hFFFF_FFFF); md = 1'b1;
        rd(8'h70, v); chk("R7 deliver", v, 32'd1);
        ind(8'h72, 2'd0, 32'hFFFF_FFFF); mt = 63;
        rd(8'h72, v); chk("R7 thresh", v, 32'd63);
        ind(8'h72, 2'd2, 32'hFFFF_FFFF); mt = 0;
        rd(8'h72, v); chk("R7 thresh clear", v, 32'd0);
        rd(8'h71, v); chk("R7 sel 71", v, 32'd0);
        rd(8'h82, v); chk("R7 sel 82", v, 32'd0);
        rd(8'hC2, v); chk("R7 sel c2", v, 32'd0);
        rd(8'h00, v); chk("R7 sel 00", v, 32'd0);
        ind(8'h82, 2'd0, 32'hFFFF_FFFF);
        ind(8'h71, 2'd0, 32'hFFFF_FFFF);
        check_arrays("R7 unmapped write");

        // R8, R10, R11: random patterns drained by claims
        for (int r = 0; r < 24; r++) begin
            lfsr = next_rand(lfsr); mp = lfsr; mp[0] = 1'b0;
            lfsr = next_rand(lfsr); me = lfsr | (r[0] ? 64'h0 : 64'hFFFF_0000_0000_0000); me[0] = 1'b0;
            ind(8'h80, 2'd0, mp[31:0]); ind(8'h81, 2'd0, mp[63:32]);
            ind(8'hC0, 2'd0, me[31:0]); ind(8'hC1, 2'd0, me[63:32]);
            md = (r % 4) != 0;
            ind(8'h70, 2'd0, 32'(md));
            check_arrays("R8 pattern");
            for (int k = 0; k < 64; k++) begin
                int t;
                t = exp_top();
                check_top("R8 R11 drain");
                if (t == 0) break;
                claim(); mp[t] = 1'b0;
            end
            claim();
            check_arrays("R10 claim empty");
        end

        // R9: threshold sweep with only identities 20 and up enabled
        mp = {{63{1'b1}}, 1'b0}; me = '0; me[63:20] = '1; md = 1'b1;
        ind(8'h80, 2'd0, mp[31:0]); ind(8'h81, 2'd0, mp[63:32]);
        ind(8'hC0, 2'd0, me[31:0]); ind(8'hC1, 2'd0, me[63:32]);
        ind(8'h70, 2'd0, 32'd1);
        for (int t = 0; t < 64; t++) begin
            ind(8'h72, 2'd0, 32'(t)); mt = t;
            check_top("R9 thresh sweep");
        end
        ind(8'h72, 2'd0, 32'd1); mt = 1;
        check_top("R9 thresh one");
        claim();
        check_arrays("R10 claim masked");

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule